// File: doc/BRIEF.md
# Character Display Memory with Side-Effect Attribute Register

The block holds two parallel display memories that share one address: a byte-wide data array, holding character codes or pixel bytes, and a 5-bit attribute array holding colour and mode per cell. The processor addresses only the data array. The attribute array is reached only through an 8-bit attribute register.

When the processor writes a data byte, the low five bits of the register go into the attribute array at the same address. When the processor reads a data byte, the attribute stored at that address is copied back into the register. Bit 7 of the register is a protect flag, and while it is set both of these side effects are suppressed.

A separate display port returns the data byte and the attribute of any cell without touching the register. The register layout is: bit 7 protect, bit 4 graphic (1) or character (0), bit 3 reverse video, and bits 2:0 foreground colour. The default depth is 1024 cells. Setting `ADDR_W` to 14 gives the full 16 KB per array.

Top module: `vram_attr_store`

## Requirements
- R1: After reset the attribute register reads as 0x00.
- R2: A register write (`reg_we`) replaces all 8 register bits at the clock edge, and `reg_rdata` shows the new value from that edge on.
- R3: A processor write stores `cpu_wdata` at `cpu_addr`. A processor read presents the stored byte on `cpu_rdata` after the clock edge that samples `cpu_re`, and `cpu_rdata` holds that byte until the next read.
- R4: With register bit 7 clear, a processor write also stores register bits 4:0 into the attribute array at the same address.
- R5: With register bit 7 set, a processor write leaves the attribute array unchanged. The data byte is still written.
- R6: With register bit 7 clear, a processor read loads the register with the addressed attribute in bits 4:0 and zeros in bits 7:5.
- R7: With register bit 7 set, a processor read leaves the register unchanged.
- R8: The display port returns `disp_data` and `disp_attr` for `disp_addr` one cycle after the address is presented, and it never changes the register.
- R9: When a register write coincides with a read-back load, the register write wins. When `cpu_we` and `cpu_re` are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the register |
| cpu_addr | input | ADDR_W | Processor cell address |
| cpu_we | input | 1 | Processor data write strobe |
| cpu_re | input | 1 | Processor data read strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, registered |
| reg_we | input | 1 | Attribute register write strobe |
| reg_wdata | input | 8 | Attribute register write value |
| reg_rdata | output | 8 | Current attribute register contents |
| disp_addr | input | ADDR_W | Display read address |
| disp_data | output | 8 | Display data byte, registered |
| disp_attr | output | 5 | Display attribute, registered |

## Verification
A wrong protect decision shows up in one of two ways. The register changes on the next cycle after a protected read. Or an attribute is overwritten, which the display port exposes one cycle after that cell is addressed. A wrong load width shows up as stale bits 6:5 on `reg_rdata` in the cycle right after a read. A priority error shows on the register one cycle after the colliding strobes.

// File: rtl/vram_attr_store.sv
module vram_attr_store #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int ATTR_W   = 5,
  parameter int REG_W    = 8,
  parameter int PROT_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [DATA_W-1:0] disp_data,
  output logic [ATTR_W-1:0] disp_attr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [ATTR_W-1:0] attr_mem [DEPTH];
  logic [REG_W-1:0]  latch_q;

  wire prot    = latch_q[PROT_BIT];
  wire rd_go   = cpu_re && !cpu_we;
  wire attr_wr = cpu_we && !prot;
  wire ld_go   = rd_go && !prot && !reg_we;

  assign reg_rdata = latch_q;

  always_ff @(posedge clk) begin
    if (cpu_we) data_mem[cpu_addr] <= cpu_wdata;
    if (attr_wr) attr_mem[cpu_addr] <= latch_q[ATTR_W-1:0];
    if (rd_go) cpu_rdata <= data_mem[cpu_addr];
    disp_data <= data_mem[disp_addr];
    disp_attr <= attr_mem[disp_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      latch_q <= '0;
    else if (reg_we) latch_q <= reg_wdata;
    else if (ld_go)  latch_q <= {{(REG_W-ATTR_W){1'b0}}, attr_mem[cpu_addr]};
  end

  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == $past(reg_wdata));

  assert_load_clears_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && !cpu_we && !reg_we && !reg_rdata[PROT_BIT]) |=> reg_rdata[REG_W-1:ATTR_W] == '0);

  assert_protect_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_re && reg_rdata[PROT_BIT] && !reg_we) |=> $stable(reg_rdata));

  assert_no_read_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && (!cpu_re || cpu_we)) |=> $stable(reg_rdata));
endmodule

// File: tb/test_vram_attr_store.sv
`timescale 1ns/1ps
module test_vram_attr_store;
  logic clk = 0, rst_n = 0;
  logic [9:0] cpu_addr = '0, disp_addr = '0;
  logic cpu_we = 0, cpu_re = 0, reg_we = 0;
  logic [7:0] cpu_wdata = '0, reg_wdata = '0;
  logic [7:0] cpu_rdata, reg_rdata, disp_data;
  logic [4:0] disp_attr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vram_attr_store i_vram_attr_store (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .disp_addr(disp_addr), .disp_data(disp_data), .disp_attr(disp_attr));

  // op: 0 register write, 1 data write, 2 data read, 3 display read
  // fields: op[40:39] addr[38:29] wdata[28:21] exp_data[20:13] exp_reg[12:5] exp_attr[4:0]
  localparam logic [40:0] VEC [12] = '{
    {2'd0, 10'd0, 8'h1B, 8'h00, 8'h1B, 5'h00},
    {2'd1, 10'd5, 8'hA5, 8'h00, 8'h1B, 5'h00},
    {2'd0, 10'd0, 8'h0C, 8'h00, 8'h0C, 5'h00},
    {2'd1, 10'd6, 8'h3C, 8'h00, 8'h0C, 5'h00},
    {2'd3, 10'd5, 8'h00, 8'hA5, 8'h0C, 5'h1B},
    {2'd0, 10'd0, 8'h87, 8'h00, 8'h87, 5'h00},
    {2'd1, 10'd5, 8'h5A, 8'h00, 8'h87, 5'h00},
    {2'd3, 10'd5, 8'h00, 8'h5A, 8'h87, 5'h1B},
    {2'd2, 10'd6, 8'h00, 8'h3C, 8'h87, 5'h00},
    {2'd0, 10'd0, 8'h60, 8'h00, 8'h60, 5'h00},
    {2'd2, 10'd5, 8'h00, 8'h5A, 8'h1B, 5'h00},
    {2'd2, 10'd6, 8'h00, 8'h3C, 8'h0C, 5'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_we = 0; cpu_re = 0; reg_we = 0;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset register", reg_rdata, 8'h00);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] op;
      string tag;
      op = VEC[i][40:39];
      idle();
      cpu_addr = VEC[i][38:29];
      disp_addr = VEC[i][38:29];
      cpu_wdata = VEC[i][28:21];
      reg_wdata = VEC[i][28:21];
      case (op)
        2'd0: begin reg_we = 1; tag = "R2"; end
        2'd1: begin cpu_we = 1; tag = "R4"; end
        2'd2: begin cpu_re = 1; tag = "R6"; end
        default: tag = "R8";
      endcase
      if (i == 6 || i == 7) tag = "R5";
      if (i == 8) tag = "R7";
      @(posedge clk); #1;
      idle();
      chk(tag, reg_rdata, VEC[i][12:5]);
      if (op == 2'd2) chk("R3 read data", cpu_rdata, VEC[i][20:13]);
      if (op == 2'd3) begin
        chk(tag, disp_data, VEC[i][20:13]);
        chk(tag, {3'b000, disp_attr}, {3'b000, VEC[i][4:0]});
      end
      @(negedge clk);
    end

    // R3: read data holds while no new read occurs
    @(negedge clk);
    chk("R3 hold", cpu_rdata, 8'h3C);

    // R9: register write beats read-back load in the same cycle
    reg_we = 1; reg_wdata = 8'h11; cpu_re = 1; cpu_addr = 10'd5;
    @(posedge clk); #1; idle();
    chk("R9 reg write wins", reg_rdata, 8'h11);
    chk("R3 concurrent read", cpu_rdata, 8'h5A);
    @(negedge clk);

    // R9: write wins over read when both strobes are high
    cpu_we = 1; cpu_re = 1; cpu_addr = 10'd7; cpu_wdata = 8'h77;
    @(posedge clk); #1; idle();
    chk("R9 read ignored, register kept", reg_rdata, 8'h11);
    chk("R9 read ignored, rdata kept", cpu_rdata, 8'h5A);
    @(negedge clk);
    disp_addr = 10'd7;
    @(posedge clk); #1;
    chk("R9 write done data", disp_data, 8'h77);
    chk("R4 write done attr", {3'b000, disp_attr}, 8'h11);
    @(negedge clk);

    // R8: display reads leave the register untouched
    disp_addr = 10'd6;
    @(posedge clk); #1;
    chk("R8 display attr", {3'b000, disp_attr}, 8'h0C);
    chk("R8 register kept", reg_rdata, 8'h11);
    @(negedge clk);

    // R1: reset again clears the register
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    chk("R1 re-reset", reg_rdata, 8'h00);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule